// File: doc/BRIEF.md
# Per-Pipe Buffer-Empty and Overflow Interrupt Controller

This block raises the buffer-empty interrupt for a group of USB endpoint pipes. Each pipe reports its transfer direction, whether it runs with one buffer or two buffer halves, and its transmit-completion and receive events. The block turns these events into one sticky status bit per pipe. Software clears a status bit by writing 1 to it.

In the transmit direction a pipe flags when its buffered data has gone out on the bus. With two halves, the pipe flags only when the opposite half is not holding a real packet: it must not be committed for sending and must hold fewer than eight bytes. In the receive direction a pipe flags when a packet arrives that is longer than the pipe's maximum packet size. In that case the block also asks the pipe's handshake logic to answer STALL, but only when the maximum packet size is nonzero.

Per-pipe enables and a global enable combine the status bits into a registered summary flag and a registered, level-sensitive interrupt line.

Top module: `pipe_empty_irq`

## Requirements
- R1: After reset, `stat_o`, `sum_o` and `irq_o` are all 0.
- R2: A pipe with `pipe_dir_tx`=1 and `pipe_dbl`=0 that sees `half_tx_done` at a clock edge has its `stat_o` bit set from that edge on.
- R3: A pipe with `pipe_dir_tx`=1 and `pipe_dbl`=1 sets its status bit on `half_tx_done` when `peer_ready`=0 and `peer_bytes` is below 8. This covers an empty peer half (`peer_bytes`=0).
- R4: A pipe in double-buffer transmit mode does not set its status bit on `half_tx_done` when `peer_ready`=1 or when `peer_bytes` is 8 or more.
- R5: A pipe with `pipe_dir_tx`=0 sets its status bit on `rx_done` when `rx_len` is greater than `max_pkt`, for every value of `max_pkt` including 0. It leaves the bit unchanged when `rx_len` is no greater than `max_pkt`.
- R6: `stall_o` for a pipe is 1 in the same cycle that `rx_done` shows an oversize packet on a receive pipe with a nonzero `max_pkt`, and it is 0 in every other case.
- R7: `half_tx_done` has no effect on a receive pipe, and `rx_done` has no effect on a transmit pipe. This applies to both status and stall.
- R8: A status bit stays set until software writes 1 to its `stat_clr` bit. When a set event and a clear arrive in the same cycle, the bit stays set. Writing 1 to the clear bit of another pipe leaves the bit untouched.
- R9: Status bits are set whatever the values of `pipe_irq_en` and `glob_irq_en`.
- R10: `sum_o` is the OR of (`stat_o` AND `pipe_irq_en`), registered one cycle after the status. `irq_o` is the same OR gated by `glob_irq_en`, registered on the same cycle.
- R11: `sum_o` and `irq_o` drop once every enabled status bit is cleared, even while disabled pipes still hold set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_dir_tx | input | NPIPE | 1 = pipe transmits, 0 = pipe receives |
| pipe_dbl | input | NPIPE | 1 = pipe uses two buffer halves |
| half_tx_done | input | NPIPE | Pulse: a buffer (half) finished sending |
| peer_ready | input | NPIPE | The opposite half holds a packet committed for sending |
| peer_bytes | input | NPIPE*LENW | Bytes currently written into the opposite half |
| rx_done | input | NPIPE | Pulse: a received packet ended |
| rx_len | input | NPIPE*LENW | Length of that received packet |
| max_pkt | input | NPIPE*LENW | Maximum packet size of each pipe |
| stat_clr | input | NPIPE | Write-1-to-clear strobes for the status bits |
| pipe_irq_en | input | NPIPE | Per-pipe interrupt enables |
| glob_irq_en | input | 1 | Global buffer-empty interrupt enable |
| stat_o | output | NPIPE | Sticky per-pipe status bits |
| sum_o | output | 1 | Registered summary of enabled status bits |
| irq_o | output | 1 | Registered interrupt line |
| stall_o | output | NPIPE | Same-cycle STALL request per pipe |

## Verification
The bench provokes a clear strobe and a new set event in the same cycle, on the same pipe. The status bit must remain 1 afterwards. It also drives a clear on a neighbouring pipe in the same cycle, which must leave the bit alone. A second pairing puts a stall request and a status set in the same cycle. The bench checks `stall_o` combinationally before the edge and the status bit after it, and does this for every pairing of packet length and maximum size. Expected values for all of these sweeps are computed by comparing the driven length and size numbers.

// File: rtl/pipe_empty_pkg.sv
package pipe_empty_pkg;
    parameter int unsigned DEF_NPIPE      = 10;
    parameter int unsigned DEF_LENW       = 11;
    parameter int unsigned DEF_FILL_LIMIT = 8;
endpackage

// File: rtl/pipe_evt_detect.sv
module pipe_evt_detect #(
    parameter int unsigned LENW       = pipe_empty_pkg::DEF_LENW,
    parameter int unsigned FILL_LIMIT = pipe_empty_pkg::DEF_FILL_LIMIT
) (
    input  logic            dir_tx,
    input  logic            dbl,
    input  logic            tx_done,
    input  logic            peer_rdy,
    input  logic [LENW-1:0] peer_cnt,
    input  logic            rx_end,
    input  logic [LENW-1:0] pkt_len,
    input  logic [LENW-1:0] pkt_max,
    output logic            set_evt,
    output logic            stall_evt
);
    localparam logic [LENW-1:0] LIMIT = LENW'(FILL_LIMIT);

    logic peer_light;
    logic tx_hit;
    logic rx_ovf;

    always_comb begin
        // opposite half holds no real packet yet
        peer_light = !peer_rdy && (peer_cnt < LIMIT);
        tx_hit     = dir_tx && tx_done && (!dbl || peer_light);
        rx_ovf     = !dir_tx && rx_end && (pkt_len > pkt_max);
        set_evt    = tx_hit || rx_ovf;
        stall_evt  = rx_ovf && (pkt_max != '0);
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int unsigned NPIPE = pipe_empty_pkg::DEF_NPIPE
) (
    input  logic [NPIPE-1:0] stat,
    input  logic [NPIPE-1:0] en,
    input  logic             glob_en,
    output logic             any_en,
    output logic             irq_req
);
    always_comb begin
        any_en  = |(stat & en);
        irq_req = any_en && glob_en;
    end
endmodule

// File: rtl/pipe_empty_irq.sv
module pipe_empty_irq #(
    parameter int unsigned NPIPE      = pipe_empty_pkg::DEF_NPIPE,
    parameter int unsigned LENW       = pipe_empty_pkg::DEF_LENW,
    parameter int unsigned FILL_LIMIT = pipe_empty_pkg::DEF_FILL_LIMIT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPIPE-1:0]           pipe_dir_tx,
    input  logic [NPIPE-1:0]           pipe_dbl,
    input  logic [NPIPE-1:0]           half_tx_done,
    input  logic [NPIPE-1:0]           peer_ready,
    input  logic [NPIPE-1:0][LENW-1:0] peer_bytes,
    input  logic [NPIPE-1:0]           rx_done,
    input  logic [NPIPE-1:0][LENW-1:0] rx_len,
    input  logic [NPIPE-1:0][LENW-1:0] max_pkt,
    input  logic [NPIPE-1:0]           stat_clr,
    input  logic [NPIPE-1:0]           pipe_irq_en,
    input  logic                       glob_irq_en,
    output logic [NPIPE-1:0]           stat_o,
    output logic                       sum_o,
    output logic                       irq_o,
    output logic [NPIPE-1:0]           stall_o
);
    typedef struct packed {
        logic [NPIPE-1:0] stat;
        logic             sum;
        logic             irq;
    } state_t;

    state_t           st_d, st_q;
    logic [NPIPE-1:0] set_vec;
    logic             any_en;
    logic             irq_req;

    for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
        pipe_evt_detect #(
            .LENW       (LENW),
            .FILL_LIMIT (FILL_LIMIT)
        ) det_i (
            .dir_tx    (pipe_dir_tx[p]),
            .dbl       (pipe_dbl[p]),
            .tx_done   (half_tx_done[p]),
            .peer_rdy  (peer_ready[p]),
            .peer_cnt  (peer_bytes[p]),
            .rx_end    (rx_done[p]),
            .pkt_len   (rx_len[p]),
            .pkt_max   (max_pkt[p]),
            .set_evt   (set_vec[p]),
            .stall_evt (stall_o[p])
        );
    end

    irq_merge #(.NPIPE(NPIPE)) merge_i (
        .stat    (st_q.stat),
        .en      (pipe_irq_en),
        .glob_en (glob_irq_en),
        .any_en  (any_en),
        .irq_req (irq_req)
    );

    always_comb begin
        st_d      = st_q;
        // a set in the same cycle as a clear wins
        st_d.stat = (st_q.stat & ~stat_clr) | set_vec;
        st_d.sum  = any_en;
        st_d.irq  = irq_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign sum_o  = st_q.sum;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/pipe_empty_irq_chk.sv
module pipe_empty_irq_chk #(
    parameter int unsigned NPIPE = pipe_empty_pkg::DEF_NPIPE,
    parameter int unsigned LENW  = pipe_empty_pkg::DEF_LENW
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NPIPE-1:0]           pipe_dir_tx,
    input logic [NPIPE-1:0]           pipe_dbl,
    input logic [NPIPE-1:0]           half_tx_done,
    input logic [NPIPE-1:0]           peer_ready,
    input logic [NPIPE-1:0][LENW-1:0] peer_bytes,
    input logic [NPIPE-1:0]           rx_done,
    input logic [NPIPE-1:0][LENW-1:0] rx_len,
    input logic [NPIPE-1:0][LENW-1:0] max_pkt,
    input logic [NPIPE-1:0]           stat_clr,
    input logic [NPIPE-1:0]           pipe_irq_en,
    input logic                       glob_irq_en,
    input logic [NPIPE-1:0]           stat_o,
    input logic                       sum_o,
    input logic                       irq_o,
    input logic [NPIPE-1:0]           stall_o
);
    assert_irq_implies_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> sum_o);

    assert_glob_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_irq_en |=> !irq_o);

    for (genvar p = 0; p < NPIPE; p++) begin : g_chk
        assert_single_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pipe_dir_tx[p] && !pipe_dbl[p] && half_tx_done[p]) |=> stat_o[p]);

        assert_dbl_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat_o[p] && pipe_dir_tx[p] && pipe_dbl[p] &&
             (peer_ready[p] || peer_bytes[p] >= LENW'(8))) |=> !stat_o[p]);

        assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            stall_o[p] |-> (rx_done[p] && !pipe_dir_tx[p] && max_pkt[p] != '0));

        assert_stall_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            stall_o[p] |=> stat_o[p]);

        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[p] && !stat_clr[p]) |=> stat_o[p]);
    end
endmodule

bind pipe_empty_irq pipe_empty_irq_chk #(.NPIPE(NPIPE), .LENW(LENW)) chk_i (.*);

// File: tb/pipe_empty_irq_tb.sv
module pipe_empty_irq_tb_top;
    localparam int NP = 10;
    localparam int LW = 11;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      pipe_dir_tx = '1;
    logic [NP-1:0]      pipe_dbl = '0;
    logic [NP-1:0]      half_tx_done = '0;
    logic [NP-1:0]      peer_ready = '0;
    logic [NP-1:0][LW-1:0] peer_bytes = '0;
    logic [NP-1:0]      rx_done = '0;
    logic [NP-1:0][LW-1:0] rx_len = '0;
    logic [NP-1:0][LW-1:0] max_pkt = '0;
    logic [NP-1:0]      stat_clr = '0;
    logic [NP-1:0]      pipe_irq_en = '0;
    logic               glob_irq_en = 1'b0;
    logic [NP-1:0]      stat_o;
    logic               sum_o;
    logic               irq_o;
    logic [NP-1:0]      stall_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pipe_empty_irq dut_i (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        stat_clr = '1;
        step();
        stat_clr = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] exp_v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(stat_o == '0, "R1 stat", int'(stat_o), 0);
        chk(sum_o == 1'b0, "R1 sum", int'(sum_o), 0);
        chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
        rst_n = 1'b1;
        step();

        // R2 single buffer transmit on every pipe, accumulating
        exp_v = '0;
        for (int p = 0; p < NP; p++) begin
            half_tx_done = NP'(1) << p;
            step();
            half_tx_done = '0;
            exp_v[p] = 1'b1;
            chk(stat_o == exp_v, "R2 single tx", int'(stat_o), int'(exp_v));
        end
        clear_all();
        chk(stat_o == '0, "R8 clear all", int'(stat_o), 0);

        // R3 R4 double buffer sweep on pipe 3
        pipe_dbl[3] = 1'b1;
        for (int rdy = 0; rdy < 2; rdy++) begin
            for (int b = 0; b < 16; b++) begin
                peer_ready[3] = rdy[0];
                peer_bytes[3] = LW'(b);
                half_tx_done[3] = 1'b1;
                step();
                half_tx_done[3] = 1'b0;
                if (rdy == 0 && b < 8)
                    chk(stat_o[3] == 1'b1, "R3 dbl set", int'(stat_o[3]), 1);
                else
                    chk(stat_o[3] == 1'b0, "R4 dbl held", int'(stat_o[3]), 0);
                clear_all();
            end
        end
        peer_ready = '0;
        peer_bytes = '0;
        pipe_dbl = '0;

        // R5 R6 receive oversize sweep on pipe 5
        pipe_dir_tx[5] = 1'b0;
        for (int m = 0; m < 3; m++) begin
            int mx;
            mx = (m == 0) ? 0 : ((m == 1) ? 8 : 64);
            for (int len = 0; len < 72; len++) begin
                bit ovf;
                ovf = (len > mx);
                max_pkt[5] = LW'(mx);
                rx_len[5] = LW'(len);
                rx_done[5] = 1'b1;
                #1;
                chk(stall_o[5] == (ovf && mx != 0), "R6 stall",
                    int'(stall_o[5]), int'(ovf && mx != 0));
                chk(stall_o[4:0] == '0 && stall_o[9:6] == '0, "R6 other stall", 1, 0);
                step();
                rx_done[5] = 1'b0;
                chk(stat_o[5] == ovf, "R5 rx status", int'(stat_o[5]), int'(ovf));
                clear_all();
            end
        end
        pipe_dir_tx = '1;

        // R7 direction gating
        pipe_dir_tx[2] = 1'b0;
        half_tx_done[2] = 1'b1;
        step();
        half_tx_done[2] = 1'b0;
        chk(stat_o == '0, "R7 tx_done on rx pipe", int'(stat_o), 0);
        pipe_dir_tx[2] = 1'b1;
        max_pkt[2] = LW'(4);
        rx_len[2] = LW'(100);
        rx_done[2] = 1'b1;
        #1;
        chk(stall_o == '0, "R7 stall on tx pipe", int'(stall_o), 0);
        step();
        rx_done[2] = 1'b0;
        chk(stat_o == '0, "R7 rx_done on tx pipe", int'(stat_o), 0);

        // R8 clear versus set collision
        half_tx_done[1] = 1'b1;
        step();
        half_tx_done[1] = 1'b0;
        stat_clr[1] = 1'b1;
        stat_clr[0] = 1'b1;
        half_tx_done[1] = 1'b1;
        step();
        stat_clr = '0;
        half_tx_done = '0;
        chk(stat_o == 10'b0000000010, "R8 set wins", int'(stat_o), 2);
        stat_clr[7] = 1'b1;
        step();
        stat_clr = '0;
        chk(stat_o[1] == 1'b1, "R8 other clr", int'(stat_o[1]), 1);
        step();
        chk(stat_o[1] == 1'b1, "R8 sticky", int'(stat_o[1]), 1);
        stat_clr[1] = 1'b1;
        step();
        stat_clr = '0;
        chk(stat_o == '0, "R8 w1c", int'(stat_o), 0);

        // R9 set while disabled
        half_tx_done[8] = 1'b1;
        step();
        half_tx_done = '0;
        chk(stat_o[8] == 1'b1, "R9 set disabled", int'(stat_o[8]), 1);
        step();
        chk(sum_o == 1'b0 && irq_o == 1'b0, "R9 no irq", int'(irq_o), 0);
        clear_all();

        // R10 summary and interrupt timing
        pipe_irq_en[4] = 1'b1;
        glob_irq_en = 1'b1;
        half_tx_done[4] = 1'b1;
        step();
        half_tx_done = '0;
        chk(stat_o[4] == 1'b1 && sum_o == 1'b0, "R10 sum lag", int'(sum_o), 0);
        step();
        chk(sum_o == 1'b1, "R10 sum", int'(sum_o), 1);
        chk(irq_o == 1'b1, "R10 irq", int'(irq_o), 1);
        glob_irq_en = 1'b0;
        step();
        chk(irq_o == 1'b0 && sum_o == 1'b1, "R10 glob gate", int'(irq_o), 0);
        glob_irq_en = 1'b1;
        step();
        chk(irq_o == 1'b1, "R10 regate", int'(irq_o), 1);

        // R11 clear of enabled bits drops summary despite disabled bit
        half_tx_done[6] = 1'b1;
        step();
        half_tx_done = '0;
        stat_clr[4] = 1'b1;
        step();
        stat_clr = '0;
        chk(stat_o == 10'b0001000000, "R11 status", int'(stat_o), 64);
        step();
        chk(sum_o == 1'b0, "R11 sum", int'(sum_o), 0);
        chk(irq_o == 1'b0, "R11 irq", int'(irq_o), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule